// File: doc/BRIEF.md
# Preset-Loaded Programmable Loop Divider

This block divides the clock coming from a divide-by-ten prescaler in a phase-locked synthesizer loop. It makes one output pulse per divider cycle, and that pulse goes to the loop's phase detector. A single BCD programming digit sets the cycle length anywhere from 20 to 29 prescaler clocks. Seen from the oscillator ahead of the prescaler, the overall ratio is therefore 200 to 290 in steps of ten.

The count chain has two cascaded stages: a units stage and a tens stage. At every reload the tens stage starts from zero and the units stage starts from the latched digit. When the chain shows 25, a pair of sequence flip-flops is armed. Two clocks later the output goes high and the counters are held at their preset. Two clocks after that the output drops, and counting resumes from the preset. Two strobes write the programming register: one captures the digit, the other captures two band-select bits that are presented as registered outputs.

Top module: `dv_loop_divider`

## Requirements
- R1: With a latched digit d in 0..9, the time between successive rising edges of `div_pulse` is 29 - d clocks, which is an overall ratio of 290 - 10*d when the ten-fold prescale is included.
- R2: A value of 10 to 15 on `prog_digit` is stored as 9 when strobed, so the cycle is never shorter than 20 clocks.
- R3: Each time `div_pulse` rises, it stays high for exactly two clocks and then goes low.
- R4: A digit captured by `ld_digit` is used from the next counter reload only. The cycle already running when the strobe arrives keeps the previous digit.
- R5: `band_out` takes the value of `band_in` one clock after `ld_band` is high and holds it otherwise. `ld_digit` does not change `band_out`, and `ld_band` does not change the cycle length.
- R6: A synchronous active-high `rst` clears the stored digit to 0, clears `band_out` to 0 and forces `div_pulse` low. After `rst` is released, the first rising edge of `div_pulse` comes 27 clocks later.
- R7: The low time of `div_pulse` between a falling edge and the next rising edge is 27 - d clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock that the divider counts |
| rst | input | 1 | Synchronous active-high reset |
| prog_digit | input | 4 | BCD programming digit |
| band_in | input | 2 | Band-select bits to be latched |
| ld_digit | input | 1 | Strobe that captures `prog_digit` |
| ld_band | input | 1 | Strobe that captures `band_in` |
| div_pulse | output | 1 | Registered divider output pulse to the phase detector |
| band_out | output | 2 | Registered latched band-select bits |

## Verification
The hardest case to reach from the ports is a new digit arriving while a cycle is already under way. The old preset has to finish that cycle, and the new one has to take over at exactly the next reload. To reach it, the bench waits for an output rise, which marks the point where the counters are reloaded. It then strobes a different digit a few clocks later and measures the next two rise-to-rise periods separately. The first period must still follow the old digit and the second must follow the new one. Band strobes are also interleaved with digit strobes, so that each half of the programming register is shown to leave the other half alone.

// File: rtl/dv_div_pkg.sv
package dv_div_pkg;

  // Sequence state: bit 1 drives the output and holds the counters,
  // bit 0 marks that the end-of-cycle detect has been seen.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'b00,
    SEQ_ARMED = 2'b01,
    SEQ_HIGH1 = 2'b11,
    SEQ_HIGH2 = 2'b10
  } seq_state_e;

  localparam int UNITS_MOD = 10;

endpackage

// File: rtl/dv_prog_latch.sv
module dv_prog_latch #(
  parameter int DIGIT_W   = 4,
  parameter int BAND_W    = 2,
  parameter int MAX_DIGIT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic [BAND_W-1:0]  band_in,
  input  logic               ld_digit,
  input  logic               ld_band,
  output logic [DIGIT_W-1:0] digit_q,
  output logic [BAND_W-1:0]  band_q
);

  localparam int CODE_MAX = (1 << DIGIT_W) - 1;

  logic [DIGIT_W-1:0] digit_safe;

  generate
    if (CODE_MAX > MAX_DIGIT) begin : g_clamp
      always_comb begin
        if (int'(digit_in) > MAX_DIGIT) digit_safe = DIGIT_W'(MAX_DIGIT);
        else                            digit_safe = digit_in;
      end
    end else begin : g_pass
      assign digit_safe = digit_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_q <= '0;
    end else if (ld_digit) begin
      digit_q <= digit_safe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      band_q <= '0;
    end else if (ld_band) begin
      band_q <= band_in;
    end
  end

endmodule

// File: rtl/dv_count_chain.sv
module dv_count_chain
  import dv_div_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int DETECT  = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [DIGIT_W-1:0] preset,
  output logic               hit
);

  localparam int TENS_MAX = DETECT / UNITS_MOD + 1;
  localparam int TENS_W   = $clog2(TENS_MAX + 1);
  localparam int HIT_TENS = DETECT / UNITS_MOD;
  localparam int HIT_UNIT = DETECT % UNITS_MOD;

  logic [DIGIT_W-1:0] units_q;
  logic [TENS_W-1:0]  tens_q;
  logic               units_wrap;

  assign units_wrap = (int'(units_q) == UNITS_MOD - 1);

  // Units stage: reloaded with the preset while held
  always_ff @(posedge clk) begin
    if (rst) begin
      units_q <= '0;
    end else if (hold) begin
      units_q <= preset;
    end else if (units_wrap) begin
      units_q <= '0;
    end else begin
      units_q <= units_q + 1'b1;
    end
  end

  // Tens stage: always restarts from zero, advances on units carry
  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tens_q <= '0;
    end else if (units_wrap) begin
      tens_q <= tens_q + 1'b1;
    end
  end

  assign hit = (int'(tens_q) == HIT_TENS) && (int'(units_q) == HIT_UNIT);

endmodule

// File: rtl/dv_end_seq.sv
module dv_end_seq
  import dv_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic pulse,
  output logic hold
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    unique case (state_q)
      SEQ_IDLE:  state_d = hit ? SEQ_ARMED : SEQ_IDLE;
      SEQ_ARMED: state_d = SEQ_HIGH1;
      SEQ_HIGH1: state_d = SEQ_HIGH2;
      SEQ_HIGH2: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  assign pulse = state_q[1];
  assign hold  = state_q[1];

endmodule

// File: rtl/dv_loop_divider.sv
module dv_loop_divider #(
  parameter int DIGIT_W   = 4,
  parameter int BAND_W    = 2,
  parameter int MAX_DIGIT = 9,
  parameter int DETECT    = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] prog_digit,
  input  logic [BAND_W-1:0]  band_in,
  input  logic               ld_digit,
  input  logic               ld_band,
  output logic               div_pulse,
  output logic [BAND_W-1:0]  band_out
);

  logic [DIGIT_W-1:0] preset_q;
  logic               hit;
  logic               hold;

  dv_prog_latch #(
    .DIGIT_W   (DIGIT_W),
    .BAND_W    (BAND_W),
    .MAX_DIGIT (MAX_DIGIT)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .digit_in (prog_digit),
    .band_in  (band_in),
    .ld_digit (ld_digit),
    .ld_band  (ld_band),
    .digit_q  (preset_q),
    .band_q   (band_out)
  );

  dv_count_chain #(
    .DIGIT_W (DIGIT_W),
    .DETECT  (DETECT)
  ) u_chain (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .preset (preset_q),
    .hit    (hit)
  );

  dv_end_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .pulse (div_pulse),
    .hold  (hold)
  );

endmodule

// File: rtl/dv_loop_divider_chk.sv
module dv_loop_divider_chk #(
  parameter int DIGIT_W   = 4,
  parameter int BAND_W    = 2,
  parameter int MAX_DIGIT = 9,
  parameter int DETECT    = 25
) (
  input logic               clk,
  input logic               rst,
  input logic               ld_digit,
  input logic               ld_band,
  input logic [BAND_W-1:0]  band_in,
  input logic [BAND_W-1:0]  band_out,
  input logic               div_pulse,
  input logic [DIGIT_W-1:0] preset_q
);

  localparam int LOW_MAX = DETECT + 2;
  localparam int LOW_MIN = DETECT + 2 - MAX_DIGIT;
  localparam int LC_W    = $clog2(LOW_MAX + 2) + 1;

  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || div_pulse) low_cnt <= '0;
    else if (int'(low_cnt) <= LOW_MAX) low_cnt <= low_cnt + 1'b1;
  end

  // R1 / R7: the low stretch before each rise lies within the programmable range
  a_r1_low_window: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pulse) |-> (int'(low_cnt) >= LOW_MIN && int'(low_cnt) <= LOW_MAX));

  // R2: the stored digit never exceeds the largest BCD value
  a_r2_clamp: assert property (@(posedge clk) disable iff (rst)
    ld_digit |=> (int'(preset_q) <= MAX_DIGIT));

  // R3: two clocks high, then low
  a_r3_high_two: assert property (@(posedge clk) disable iff (rst)
    $rose(div_pulse) |=> div_pulse ##1 !div_pulse);

  // R5: band bits load on their strobe and hold otherwise
  a_r5_band_load: assert property (@(posedge clk) disable iff (rst)
    ld_band |=> (band_out == $past(band_in)));

  a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_band |=> $stable(band_out));

  // R6: reset leaves the output low and the band bits cleared
  a_r6_reset: assert property (@(posedge clk)
    rst |=> (!div_pulse && band_out == '0));

endmodule

bind dv_loop_divider dv_loop_divider_chk #(
  .DIGIT_W   (DIGIT_W),
  .BAND_W    (BAND_W),
  .MAX_DIGIT (MAX_DIGIT),
  .DETECT    (DETECT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_digit  (ld_digit),
  .ld_band   (ld_band),
  .band_in   (band_in),
  .band_out  (band_out),
  .div_pulse (div_pulse),
  .preset_q  (preset_q)
);

// File: tb/sim_dv_loop_divider.sv
`timescale 1ns/1ps
module sim_dv_loop_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] prog_digit = '0;
  logic [1:0] band_in = '0;
  logic       ld_digit = 1'b0;
  logic       ld_band = 1'b0;
  logic       div_pulse;
  logic [1:0] band_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dv_loop_divider u0 (
    .clk        (clk),
    .rst        (rst),
    .prog_digit (prog_digit),
    .band_in    (band_in),
    .ld_digit   (ld_digit),
    .ld_band    (ld_band),
    .div_pulse  (div_pulse),
    .band_out   (band_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int t);
    logic prev;
    bit   seen;
    prev = div_pulse;
    seen = 1'b0;
    while (!seen) begin
      @(negedge clk);
      if (div_pulse && !prev) seen = 1'b1;
      prev = div_pulse;
    end
    t = cyc;
  endtask

  task automatic load_digit(input int d);
    @(negedge clk);
    prog_digit = 4'(d);
    ld_digit   = 1'b1;
    @(negedge clk);
    ld_digit   = 1'b0;
  endtask

  task automatic load_band(input logic [1:0] b);
    @(negedge clk);
    band_in = b;
    ld_band = 1'b1;
    @(negedge clk);
    ld_band = 1'b0;
  endtask

  task automatic measure_period(output int p);
    int a;
    int b;
    wait_rise(a);
    wait_rise(b);
    p = b - a;
  endtask

  task automatic do_reset_and_check(input string tag);
    int r0;
    int t;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, {"R6 pulse low in reset ", tag}, int'(div_pulse), 0);
    chk(band_out == 2'b00, {"R6 band cleared ", tag}, int'(band_out), 0);
    rst = 1'b0;
    r0 = cyc;
    wait_rise(t);
    chk(t - r0 == 27, {"R6 first rise after release ", tag}, t - r0, 27);
  endtask

  task automatic test_reset();
    do_reset_and_check("initial");
  endtask

  task automatic test_ratios();
    for (int d = 0; d <= 9; d++) begin
      int p;
      int b;
      int c;
      load_digit(d);
      wait_rise(b);
      measure_period(p);
      chk(p == 29 - d, $sformatf("R1 period digit %0d", d), p, 29 - d);
      chk(10 * p == 290 - 10 * d, $sformatf("R1 overall ratio digit %0d", d), 10 * p, 290 - 10 * d);
      wait_rise(b);
      @(negedge clk);
      chk(div_pulse == 1'b1, $sformatf("R3 second high clock digit %0d", d), int'(div_pulse), 1);
      @(negedge clk);
      chk(div_pulse == 1'b0, $sformatf("R3 low after two clocks digit %0d", d), int'(div_pulse), 0);
      wait_rise(c);
      chk(c - (b + 2) == 27 - d, $sformatf("R7 low time digit %0d", d), c - (b + 2), 27 - d);
    end
  endtask

  task automatic test_clamp();
    int codes [2] = '{12, 15};
    foreach (codes[i]) begin
      int p;
      int b;
      load_digit(codes[i]);
      wait_rise(b);
      measure_period(p);
      chk(p == 20, $sformatf("R2 clamp code %0d", codes[i]), p, 20);
    end
  endtask

  task automatic test_midload();
    int t0;
    int t1;
    int t2;
    load_digit(0);
    wait_rise(t0);
    wait_rise(t0);
    repeat (4) @(negedge clk);
    load_digit(9);
    wait_rise(t1);
    wait_rise(t2);
    chk(t1 - t0 == 29, "R4 running cycle keeps old digit", t1 - t0, 29);
    chk(t2 - t1 == 20, "R4 new digit used after reload", t2 - t1, 20);
  endtask

  task automatic test_band();
    int p;
    int b;
    load_band(2'b10);
    @(negedge clk);
    chk(band_out == 2'b10, "R5 band load 10", int'(band_out), 2);
    band_in = 2'b01;
    load_digit(3);
    @(negedge clk);
    chk(band_out == 2'b10, "R5 digit strobe leaves band", int'(band_out), 2);
    wait_rise(b);
    load_band(2'b01);
    chk(band_out == 2'b01, "R5 band load 01", int'(band_out), 1);
    measure_period(p);
    chk(p == 26, "R5 band strobe leaves period", p, 26);
    load_band(2'b11);
    chk(band_out == 2'b11, "R5 band load 11", int'(band_out), 3);
  endtask

  task automatic test_reset_mid();
    int b;
    load_digit(5);
    load_band(2'b11);
    wait_rise(b);
    repeat (7) @(negedge clk);
    do_reset_and_check("mid-run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_ratios();
    test_clamp();
    test_midload();
    test_band();
    test_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule